// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Controller

This block sits between two processor sides, called A and B, that share one clock. Each side can ring the other with four general-purpose doorbells and one non-maskable doorbell. Ringing uses a handshake. A ring sets a request bit on the sender. The same bit shows as a pending bit on the receiver. The request stays set until the receiver acknowledges it by writing 1 to the matching pending bit. While a doorbell is still unacknowledged, the sender cannot ring it again. Such an attempt is refused, and a sticky failure flag records the refusal.

Each receiver has one enable bit per general-purpose doorbell. Its interrupt output is the OR of its enabled pending bits. The non-maskable doorbell drives a separate output that no enable can gate, and it has its own acknowledge strobe. Each side can also announce that it is starting a unit reset. If the receiving side has enabled reset notification, the announcement is merged into general-purpose doorbell 3 on that side.

All commands are single-cycle strobes. All state is registered, and every state change is visible on the ports one clock after the strobe.

Top module: `xcore_doorbell`

## Requirements
- R1: A synchronous active-high reset clears every request, pending, enable, reset-notification-enable, non-maskable and failure bit on both sides.
- R2: Every 4-bit doorbell field maps doorbell n to bit 3-n, so doorbell 0 is bit 3 and doorbell 3 is bit 0. A trigger whose named doorbells are all idle sets those bits in the sender's `req` and in the receiver's `pend` one cycle later.
- R3: A trigger is refused in full if any doorbell it names, general-purpose or non-maskable, is still unacknowledged. A refused trigger sets no bit at all.
- R4: A refused trigger sets the sender's `fail` flag. The flag stays set until the sender pulses `fail_clr`. If a refusal and `fail_clr` happen in the same cycle, the flag stays set.
- R5: A receiver write with `clr_we` high clears each pending bit whose `clr_gp` bit is 1. The sender's matching request bit drops in the same cycle. Bits written 0, and bits that are not pending, are unaffected. A trigger of a doorbell in the same cycle as its acknowledge is judged against the state before the acknowledge, so the trigger is refused.
- R6: A write with `cfg_we` high loads the receiver's enable field. `irq` is high exactly when some pending bit is set and its enable bit is 1.
- R7: `trig_nmi` raises the receiver's `nmi` output one cycle later, whatever the enables hold. `nmi` stays high until the receiver pulses `clr_nmi`.
- R8: When the receiver's reset-notification enable is 1 and the sender holds `unit_rst_req` high at a clock edge, the receiver's `pend` bit 0 (doorbell 3) is set. It is cleared by acknowledging bit 0. The announcement does not touch the sender's `req`, and it is ignored while the notification enable is 0.
- R9: The A-to-B and B-to-A directions hold separate state. Commands in one direction never change the other direction's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_trig_we | input | 1 | Side A trigger strobe |
| a_trig_gp | input | 4 | Side A doorbells to ring (bit 3-n = doorbell n) |
| a_trig_nmi | input | 1 | Side A rings the non-maskable doorbell (with a_trig_we) |
| a_clr_we | input | 1 | Side A acknowledge strobe |
| a_clr_gp | input | 4 | Side A pending bits to clear, write 1 to clear |
| a_clr_nmi | input | 1 | Side A acknowledges its incoming non-maskable doorbell |
| a_fail_clr | input | 1 | Clears side A's failure flag |
| a_cfg_we | input | 1 | Side A enable write strobe |
| a_cfg_gp_en | input | 4 | Side A doorbell enables |
| a_cfg_rst_en | input | 1 | Side A reset-notification enable |
| a_unit_rst_req | input | 1 | Side A announces a unit reset to side B |
| b_trig_we | input | 1 | Side B trigger strobe |
| b_trig_gp | input | 4 | Side B doorbells to ring |
| b_trig_nmi | input | 1 | Side B rings the non-maskable doorbell (with b_trig_we) |
| b_clr_we | input | 1 | Side B acknowledge strobe |
| b_clr_gp | input | 4 | Side B pending bits to clear |
| b_clr_nmi | input | 1 | Side B acknowledges its incoming non-maskable doorbell |
| b_fail_clr | input | 1 | Clears side B's failure flag |
| b_cfg_we | input | 1 | Side B enable write strobe |
| b_cfg_gp_en | input | 4 | Side B doorbell enables |
| b_cfg_rst_en | input | 1 | Side B reset-notification enable |
| b_unit_rst_req | input | 1 | Side B announces a unit reset to side A |
| a_req | output | 4 | Side A's outstanding requests toward B |
| a_pend | output | 4 | Doorbells pending at side A |
| a_fail | output | 1 | Side A sticky refusal flag |
| a_irq | output | 1 | Side A maskable interrupt |
| a_nmi | output | 1 | Side A non-maskable interrupt |
| b_req | output | 4 | Side B's outstanding requests toward A |
| b_pend | output | 4 | Doorbells pending at side B |
| b_fail | output | 1 | Side B sticky refusal flag |
| b_irq | output | 1 | Side B maskable interrupt |
| b_nmi | output | 1 | Side B non-maskable interrupt |

## Verification
The trigger of one side and the acknowledge of the other side can land on the same edge, aimed at the same doorbell. The bench sweeps every pair of prior outstanding set and new trigger set. In half of the runs, the receiver acknowledges the whole outstanding set in the very cycle of the trigger. The model judges acceptance against the state before the acknowledge, so an overlapping trigger is expected to be refused while the bits still drop. Both directions are driven at once with complementary patterns, so any crosstalk between them shows up in the comparison.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    // Number of general-purpose doorbells per direction.
    localparam int unsigned GP_W = 4;
    // Doorbell n sits at bit GP_W-1-n; the last doorbell is bit 0.
    localparam int unsigned RST_NOTE_BIT = 0;
    localparam int unsigned SIDES = 2;

    // Commands issued by a side acting as sender.
    typedef struct packed {
        logic            trig_we;
        logic [GP_W-1:0] trig_gp;
        logic            trig_nmi;
        logic            fail_clr;
        logic            unit_rst_req;
    } tx_cmd_t;

    // Commands issued by a side acting as receiver.
    typedef struct packed {
        logic            clr_we;
        logic [GP_W-1:0] clr_gp;
        logic            clr_nmi;
        logic            cfg_we;
        logic [GP_W-1:0] cfg_gp_en;
        logic            cfg_rst_en;
    } rx_cmd_t;

    function automatic logic [GP_W-1:0] w1c_mask(input logic we, input logic [GP_W-1:0] m);
        return we ? m : '0;
    endfunction

    function automatic logic [GP_W-1:0] note_vec(input logic bit_in);
        logic [GP_W-1:0] v;
        v = '0;
        v[RST_NOTE_BIT] = bit_in;
        return v;
    endfunction

endpackage

// File: rtl/db_channel.sv
module db_channel
    import doorbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tx_cmd_t         tx,
    input  rx_cmd_t         rx,
    input  logic            rx_rst_en,
    output logic [GP_W-1:0] req,
    output logic            nmi_pend,
    output logic            fail,
    output logic            rst_pend
);

    logic            busy;
    logic            accept;
    logic            refuse;
    logic [GP_W-1:0] clr_eff;

    assign busy    = (|(tx.trig_gp & req)) | (tx.trig_nmi & nmi_pend);
    assign accept  = tx.trig_we & ~busy;
    assign refuse  = tx.trig_we & busy;
    assign clr_eff = w1c_mask(rx.clr_we, rx.clr_gp);

    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= '0;
            nmi_pend <= 1'b0;
            fail     <= 1'b0;
            rst_pend <= 1'b0;
        end else begin
            req      <= (req & ~clr_eff) | (accept ? tx.trig_gp : '0);
            nmi_pend <= (nmi_pend & ~rx.clr_nmi) | (accept & tx.trig_nmi);
            fail     <= refuse | (fail & ~tx.fail_clr);
            rst_pend <= (rst_pend & ~clr_eff[RST_NOTE_BIT]) | (tx.unit_rst_req & rx_rst_en);
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (req == '0 && !nmi_pend && !fail && !rst_pend));

    // R3
    refused_keeps_req_chk: assert property (@(posedge clk) disable iff (rst)
        (tx.trig_we && (|(tx.trig_gp & req)) && !rx.clr_we) |=> (req == $past(req)));

    // R4
    refusal_sets_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (tx.trig_we && (tx.trig_nmi && nmi_pend)) |=> fail);

    // R5
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rx.clr_we && ((rx.clr_gp & req) != '0)) |=> ((req & $past(rx.clr_gp & req)) == '0));

    // R7
    nmi_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !rx.clr_nmi) |=> nmi_pend);

endmodule

// File: rtl/db_rx_gate.sv
module db_rx_gate
    import doorbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  rx_cmd_t         rx,
    input  logic [GP_W-1:0] peer_req,
    input  logic            rst_pend,
    output logic [GP_W-1:0] pend,
    output logic            irq,
    output logic            rst_en
);

    logic [GP_W-1:0] gp_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            gp_en  <= '0;
            rst_en <= 1'b0;
        end else if (rx.cfg_we) begin
            gp_en  <= rx.cfg_gp_en;
            rst_en <= rx.cfg_rst_en;
        end
    end

    assign pend = peer_req | note_vec(rst_pend);
    assign irq  = |(pend & gp_en);

    // R6
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq);

    // R6
    masked_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (gp_en == '0) |-> !irq);

endmodule

// File: rtl/xcore_doorbell.sv
module xcore_doorbell
    import doorbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            a_trig_we,
    input  logic [GP_W-1:0] a_trig_gp,
    input  logic            a_trig_nmi,
    input  logic            a_clr_we,
    input  logic [GP_W-1:0] a_clr_gp,
    input  logic            a_clr_nmi,
    input  logic            a_fail_clr,
    input  logic            a_cfg_we,
    input  logic [GP_W-1:0] a_cfg_gp_en,
    input  logic            a_cfg_rst_en,
    input  logic            a_unit_rst_req,
    input  logic            b_trig_we,
    input  logic [GP_W-1:0] b_trig_gp,
    input  logic            b_trig_nmi,
    input  logic            b_clr_we,
    input  logic [GP_W-1:0] b_clr_gp,
    input  logic            b_clr_nmi,
    input  logic            b_fail_clr,
    input  logic            b_cfg_we,
    input  logic [GP_W-1:0] b_cfg_gp_en,
    input  logic            b_cfg_rst_en,
    input  logic            b_unit_rst_req,
    output logic [GP_W-1:0] a_req,
    output logic [GP_W-1:0] a_pend,
    output logic            a_fail,
    output logic            a_irq,
    output logic            a_nmi,
    output logic [GP_W-1:0] b_req,
    output logic [GP_W-1:0] b_pend,
    output logic            b_fail,
    output logic            b_irq,
    output logic            b_nmi
);

    tx_cmd_t         tx     [SIDES];
    rx_cmd_t         rx     [SIDES];
    logic [GP_W-1:0] req_w  [SIDES];
    logic [GP_W-1:0] pend_w [SIDES];
    logic            nmi_w  [SIDES];
    logic            fail_w [SIDES];
    logic            irq_w  [SIDES];
    logic            rp_w   [SIDES];
    logic            ren_w  [SIDES];

    assign tx[0] = {a_trig_we, a_trig_gp, a_trig_nmi, a_fail_clr, a_unit_rst_req};
    assign tx[1] = {b_trig_we, b_trig_gp, b_trig_nmi, b_fail_clr, b_unit_rst_req};
    assign rx[0] = {a_clr_we, a_clr_gp, a_clr_nmi, a_cfg_we, a_cfg_gp_en, a_cfg_rst_en};
    assign rx[1] = {b_clr_we, b_clr_gp, b_clr_nmi, b_cfg_we, b_cfg_gp_en, b_cfg_rst_en};

    // Direction d carries side d's requests to side 1-d.
    for (genvar d = 0; d < SIDES; d++) begin : g_dir
        localparam int unsigned PEER = SIDES - 1 - d;

        db_channel u_chan (
            .clk       (clk),
            .rst       (rst),
            .tx        (tx[d]),
            .rx        (rx[PEER]),
            .rx_rst_en (ren_w[PEER]),
            .req       (req_w[d]),
            .nmi_pend  (nmi_w[d]),
            .fail      (fail_w[d]),
            .rst_pend  (rp_w[PEER])
        );

        db_rx_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .rx       (rx[d]),
            .peer_req (req_w[PEER]),
            .rst_pend (rp_w[d]),
            .pend     (pend_w[d]),
            .irq      (irq_w[d]),
            .rst_en   (ren_w[d])
        );
    end

    assign a_req  = req_w[0];
    assign b_req  = req_w[1];
    assign a_pend = pend_w[0];
    assign b_pend = pend_w[1];
    assign a_fail = fail_w[0];
    assign b_fail = fail_w[1];
    assign a_irq  = irq_w[0];
    assign b_irq  = irq_w[1];
    assign a_nmi  = nmi_w[1];
    assign b_nmi  = nmi_w[0];

    // R2
    req_mirrors_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ((a_req & ~b_pend) == '0) && ((b_req & ~a_pend) == '0));

    // R9
    b_idle_keeps_b_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!b_trig_we && !a_clr_we) |=> (b_req == $past(b_req)));

endmodule

// File: tb/xcore_doorbell_tb.sv
module xcore_doorbell_tb;

    logic clk = 1'b0;
    logic rst;
    always #10 clk = ~clk;

    logic       tw [2];
    logic [3:0] tg [2];
    logic       tn [2];
    logic       cw [2];
    logic [3:0] cg [2];
    logic       cn [2];
    logic       cf [2];
    logic       ew [2];
    logic [3:0] eg [2];
    logic       er [2];
    logic       rr [2];

    logic [3:0] a_req, a_pend, b_req, b_pend;
    logic a_fail, a_irq, a_nmi, b_fail, b_irq, b_nmi;

    // model state: mq/mn/mf indexed by sender, mp/me/mr by receiver
    logic [3:0] mq [2];
    logic       mn [2];
    logic       mf [2];
    logic       mp [2];
    logic [3:0] me [2];
    logic       mr [2];

    int checks = 0;
    int errors = 0;

    xcore_doorbell u_dut (
        .clk(clk), .rst(rst),
        .a_trig_we(tw[0]), .a_trig_gp(tg[0]), .a_trig_nmi(tn[0]),
        .a_clr_we(cw[0]), .a_clr_gp(cg[0]), .a_clr_nmi(cn[0]), .a_fail_clr(cf[0]),
        .a_cfg_we(ew[0]), .a_cfg_gp_en(eg[0]), .a_cfg_rst_en(er[0]), .a_unit_rst_req(rr[0]),
        .b_trig_we(tw[1]), .b_trig_gp(tg[1]), .b_trig_nmi(tn[1]),
        .b_clr_we(cw[1]), .b_clr_gp(cg[1]), .b_clr_nmi(cn[1]), .b_fail_clr(cf[1]),
        .b_cfg_we(ew[1]), .b_cfg_gp_en(eg[1]), .b_cfg_rst_en(er[1]), .b_unit_rst_req(rr[1]),
        .a_req(a_req), .a_pend(a_pend), .a_fail(a_fail), .a_irq(a_irq), .a_nmi(a_nmi),
        .b_req(b_req), .b_pend(b_pend), .b_fail(b_fail), .b_irq(b_irq), .b_nmi(b_nmi)
    );

    task automatic idle();
        for (int s = 0; s < 2; s++) begin
            tw[s] = 0; tg[s] = 0; tn[s] = 0; cw[s] = 0; cg[s] = 0; cn[s] = 0;
            cf[s] = 0; ew[s] = 0; eg[s] = 0; er[s] = 0; rr[s] = 0;
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Advance one edge with the driven strobes, updating the model from the requirements.
    task automatic step();
        logic [3:0] nq [2];
        logic       nn [2];
        logic       nf [2];
        logic       np [2];
        logic [3:0] ne [2];
        logic       nr [2];
        for (int d = 0; d < 2; d++) begin
            int r;
            logic busy, acc;
            logic [3:0] ack;
            r    = 1 - d;
            busy = ((tg[d] & mq[d]) != 0) || (tn[d] && mn[d]);
            acc  = tw[d] && !busy;
            ack  = cw[r] ? cg[r] : 4'h0;
            nq[d] = (mq[d] & ~ack) | (acc ? tg[d] : 4'h0);
            nn[d] = (mn[d] && !cn[r]) || (acc && tn[d]);
            nf[d] = (tw[d] && busy) || (mf[d] && !cf[d]);
            np[r] = (mp[r] && !ack[0]) || (rr[d] && mr[r]);
            ne[d] = ew[d] ? eg[d] : me[d];
            nr[d] = ew[d] ? er[d] : mr[d];
        end
        @(posedge clk);
        #1;
        for (int s = 0; s < 2; s++) begin
            mq[s] = rst ? 4'h0 : nq[s];
            mn[s] = rst ? 1'b0 : nn[s];
            mf[s] = rst ? 1'b0 : nf[s];
            mp[s] = rst ? 1'b0 : np[s];
            me[s] = rst ? 4'h0 : ne[s];
            mr[s] = rst ? 1'b0 : nr[s];
        end
        idle();
    endtask

    task automatic check_all(input string tag);
        logic [3:0] pa, pb;
        pa = mq[1] | {3'b000, mp[0]};
        pb = mq[0] | {3'b000, mp[1]};
        chk(tag, "a_req",  a_req,  mq[0]);
        chk(tag, "b_req",  b_req,  mq[1]);
        chk(tag, "a_pend", a_pend, pa);
        chk(tag, "b_pend", b_pend, pb);
        chk(tag, "a_fail", {3'b0, a_fail}, {3'b0, mf[0]});
        chk(tag, "b_fail", {3'b0, b_fail}, {3'b0, mf[1]});
        chk(tag, "a_irq",  {3'b0, a_irq},  {3'b0, (pa & me[0]) != 0});
        chk(tag, "b_irq",  {3'b0, b_irq},  {3'b0, (pb & me[1]) != 0});
        chk(tag, "a_nmi",  {3'b0, a_nmi},  {3'b0, mn[1]});
        chk(tag, "b_nmi",  {3'b0, b_nmi},  {3'b0, mn[0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        for (int s = 0; s < 2; s++) begin
            mq[s] = 0; mn[s] = 0; mf[s] = 0; mp[s] = 0; me[s] = 0; mr[s] = 0;
        end
        rst = 1;
        #1;
        step();
        step();
        rst = 0;
        check_all("R1");

        // enable some interrupts on both sides so irq is exercised in the sweep
        ew[0] = 1; eg[0] = 4'b1010; ew[1] = 1; eg[1] = 4'b0110;
        step();
        check_all("R6");

        // R2 R3 R4 R5 R9: sweep prior outstanding set x new trigger set, both directions
        for (int k = 0; k < 2; k++) begin
            for (int a = 0; a < 16; a++) begin
                for (int m = 0; m < 16; m++) begin
                    cw[0] = 1; cg[0] = 4'hF; cw[1] = 1; cg[1] = 4'hF; cf[0] = 1; cf[1] = 1;
                    step();
                    tw[0] = 1; tg[0] = a[3:0]; tw[1] = 1; tg[1] = ~a[3:0];
                    step();
                    check_all("R2");
                    tw[0] = 1; tg[0] = m[3:0]; tw[1] = 1; tg[1] = ~m[3:0];
                    if (k == 1) begin
                        cw[1] = 1; cg[1] = a[3:0];
                    end
                    step();
                    if (k == 1)
                        check_all("R5");
                    else if ((a & m) != 0)
                        check_all("R3");
                    else
                        check_all("R9");
                end
            end
        end

        // R6: enable patterns against a fixed pending set, then pending patterns against a fixed enable
        cw[0] = 1; cg[0] = 4'hF; cw[1] = 1; cg[1] = 4'hF;
        step();
        tw[0] = 1; tg[0] = 4'b0100;
        step();
        for (int e = 0; e < 16; e++) begin
            ew[1] = 1; eg[1] = e[3:0];
            step();
            check_all("R6");
        end
        ew[1] = 1; eg[1] = 4'b0101;
        step();
        for (int p = 0; p < 16; p++) begin
            cw[1] = 1; cg[1] = 4'hF;
            step();
            tw[0] = 1; tg[0] = p[3:0];
            step();
            check_all("R6");
        end

        // R7: non-maskable doorbell ignores enables and holds until acknowledged
        cw[1] = 1; cg[1] = 4'hF; ew[1] = 1; eg[1] = 4'h0;
        step();
        tw[0] = 1; tn[0] = 1;
        step();
        check_all("R7");
        step();
        check_all("R7");
        tw[0] = 1; tn[0] = 1;
        step();
        check_all("R3");
        cw[1] = 1; cg[1] = 4'hF;
        step();
        check_all("R7");
        cn[1] = 1;
        step();
        check_all("R7");

        // R4: refusal and fail clear in the same cycle keep the flag set
        tw[0] = 1; tg[0] = 4'b1000;
        step();
        tw[0] = 1; tg[0] = 4'b1000; cf[0] = 1;
        step();
        check_all("R4");
        cf[0] = 1;
        step();
        check_all("R4");

        // R8: reset announcement ignored while disabled, merged into bit 0 when enabled
        cw[1] = 1; cg[1] = 4'hF;
        step();
        rr[0] = 1;
        step();
        check_all("R8");
        ew[1] = 1; eg[1] = 4'b0001; er[1] = 1;
        step();
        rr[0] = 1;
        step();
        check_all("R8");
        tw[0] = 1; tg[0] = 4'b0001;
        step();
        check_all("R8");
        cw[1] = 1; cg[1] = 4'b0001;
        step();
        check_all("R8");
        rr[1] = 1;
        step();
        check_all("R8");

        // R1: reset after activity
        tw[0] = 1; tg[0] = 4'hF; tw[1] = 1; tn[1] = 1;
        step();
        rst = 1;
        step();
        rst = 0;
        check_all("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule